// File: doc/BRIEF.md
# Page-Bounded DMA Transfer Engine

This block moves a block of words between a device data port and memory without the processor having to step through it. Software loads a memory address, a byte count, a device address and a direction through a small register port, then sets a start bit. The engine asks a bus arbiter for the memory bus, copies one word at a time, and raises an interrupt when the whole job is done.

A job is never issued as one flat run. Each run the engine makes while it holds the bus is a segment that stays inside one physical page. The job continues as a chain of such segments, and the engine gives the bus back between any two of them so other masters get a chance to win arbitration. The page size, address width, data width and count width are parameters.

Top module: `page_dma_engine`

## Requirements
- R1: After reset `irq`, `bus_req`, `mem_en`, `dev_rd` and `dev_wr` are low, and every readable register (control, status, memory address, count, device address) reads as zero.
- R2: Register index 2 holds the memory address, index 3 holds the byte count and index 4 holds the device address. Each reads back as written. Control (index 0) reads back the direction in bit 1. The stored device address appears on `dev_addr` while a job runs.
- R3: A write to control (index 0) with bit 0 set starts a job. Control bit 1 selects the direction: 0 copies device to memory, 1 copies memory to device. Words (4 bytes) move in ascending memory order, and the two low bits of the memory address and of the count are ignored.
- R4: `bus_req` stays high until `bus_gnt` is seen, and `mem_en` is never high without `bus_gnt`.
- R5: The memory accesses made during one grant all fall in a single page. Each segment moves the smaller of the remaining words and the words left before the next page boundary.
- R6: Between two segments `bus_req` goes low for at least one cycle and then rises again, so `bus_req` rises once per segment.
- R7: When the last word of a job completes, `irq` is set in the same cycle that the busy status drops.
- R8: `irq` stays high until software writes status (index 1) with bit 0 set. A status write with bit 0 clear leaves it high.
- R9: A start with a word count of zero sets `irq` on the clock edge that takes the start write, and never raises `bus_req`.
- R10: Status bit 0 reads 1 while a job is in progress. During that time, writes to control, memory address, count and device address have no effect, and that includes a second start.
- R11: `mem_rdy` or `dev_rdy` held low stretches the current access, and no word is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Register read data (combinational on reg_addr) |
| irq | output | 1 | Job-complete interrupt, sticky |
| bus_req | output | 1 | Memory bus request to the arbiter |
| bus_gnt | input | 1 | Memory bus grant from the arbiter |
| mem_en | output | 1 | Memory access valid |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory byte address, word aligned |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_rdy |
| mem_rdy | input | 1 | Memory accepts or returns the access this cycle |
| dev_addr | output | DEV_W | Device address of the running job |
| dev_rd | output | 1 | Device read request |
| dev_wr | output | 1 | Device write request |
| dev_wdata | output | DATA_W | Device write data |
| dev_rdata | input | DATA_W | Device read data, valid with dev_rdy |
| dev_rdy | input | 1 | Device completes the read or write this cycle |

## Verification
The copy is driven with several address and length patterns. A short job inside one page shows plain data movement. A long memory-to-device job that starts two words before a boundary must split into three segments of lengths 2, 16 and 2, which shows that page splitting is done at every boundary and not only at the first. A page-aligned job one word longer than a page shows where the boundary falls exactly, and a run with both ready signals toggling shows that stalls do not drop or repeat a word. A job that is held without a grant separates the busy lockout from normal programming. Zero-length starts, including counts whose only set bits are ignored, show the no-bus completion path.

// File: rtl/page_dma_pkg.sv
package page_dma_pkg;

   typedef enum logic [2:0] {
      XS_IDLE,
      XS_REQ,
      XS_FETCH,
      XS_STORE,
      XS_REL
   } xfer_state_e;

   localparam logic [2:0] RIX_CTRL  = 3'd0;
   localparam logic [2:0] RIX_STAT  = 3'd1;
   localparam logic [2:0] RIX_MADDR = 3'd2;
   localparam logic [2:0] RIX_COUNT = 3'd3;
   localparam logic [2:0] RIX_DEV   = 3'd4;

   localparam int CTRL_GO_BIT  = 0;
   localparam int CTRL_DIR_BIT = 1;
   localparam int STAT_BSY_BIT = 0;
   localparam int STAT_IRQ_BIT = 1;
   localparam int STAT_CLR_BIT = 0;

endpackage

// File: rtl/page_dma_seg.sv
module page_dma_seg #(
   parameter int PAGE_BYTES = 4096,
   parameter int WORD_BYTES = 4,
   parameter int WCNT_W     = 14
) (
   input  logic [$clog2(PAGE_BYTES)-1:0] page_ofs,
   input  logic [WCNT_W-1:0]             rem_words,
   output logic [WCNT_W-1:0]             seg_words
);
   localparam int PG_OFS_W = $clog2(PAGE_BYTES);
   localparam int OFS_W    = $clog2(WORD_BYTES);
   localparam int CMP_W    = (PG_OFS_W + 1 > WCNT_W) ? PG_OFS_W + 1 : WCNT_W;

   logic [PG_OFS_W:0] room_bytes;
   logic [CMP_W-1:0]  room_w;
   logic [CMP_W-1:0]  rem_w;

   always_comb begin
      room_bytes = (PG_OFS_W+1)'(PAGE_BYTES) - {1'b0, page_ofs};
      room_w     = CMP_W'(room_bytes >> OFS_W);
      rem_w      = CMP_W'(rem_words);
      if (rem_w <= room_w) begin
         seg_words = rem_words;
      end else begin
         seg_words = WCNT_W'(room_w);
      end
   end

endmodule

// File: rtl/page_dma_regs.sv
module page_dma_regs
   import page_dma_pkg::*;
#(
   parameter int REG_W  = 32,
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 16,
   parameter int DEV_W  = 8,
   parameter int OFS_W  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reg_wr,
   input  logic [2:0]              reg_addr,
   input  logic [REG_W-1:0]        reg_wdata,
   output logic [REG_W-1:0]        reg_rdata,
   input  logic                    busy,
   input  logic                    done_set,
   output logic                    irq,
   output logic                    irq_clr,
   output logic                    go,
   output logic                    go_dir,
   output logic [ADDR_W-OFS_W-1:0] cfg_mword,
   output logic [CNT_W-OFS_W-1:0]  cfg_words,
   output logic [DEV_W-1:0]        cfg_dev
);
   logic              dir_q;
   logic [ADDR_W-1:0] maddr_q;
   logic [CNT_W-1:0]  count_q;
   logic [DEV_W-1:0]  dev_q;
   logic              irq_q;
   logic              wr_ok;

   assign wr_ok   = reg_wr && !busy;
   assign go      = wr_ok && (reg_addr == RIX_CTRL) && reg_wdata[CTRL_GO_BIT];
   assign go_dir  = reg_wdata[CTRL_DIR_BIT];
   assign irq_clr = reg_wr && (reg_addr == RIX_STAT) && reg_wdata[STAT_CLR_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q   <= 1'b0;
         maddr_q <= '0;
         count_q <= '0;
         dev_q   <= '0;
         irq_q   <= 1'b0;
      end else begin
         if (wr_ok) begin
            case (reg_addr)
               RIX_CTRL:  dir_q   <= reg_wdata[CTRL_DIR_BIT];
               RIX_MADDR: maddr_q <= reg_wdata[ADDR_W-1:0];
               RIX_COUNT: count_q <= reg_wdata[CNT_W-1:0];
               RIX_DEV:   dev_q   <= reg_wdata[DEV_W-1:0];
               default: ;
            endcase
         end
         if (done_set) begin
            irq_q <= 1'b1;
         end else if (irq_clr) begin
            irq_q <= 1'b0;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RIX_CTRL:  reg_rdata[CTRL_DIR_BIT] = dir_q;
         RIX_STAT: begin
            reg_rdata[STAT_BSY_BIT] = busy;
            reg_rdata[STAT_IRQ_BIT] = irq_q;
         end
         RIX_MADDR: reg_rdata[ADDR_W-1:0] = maddr_q;
         RIX_COUNT: reg_rdata[CNT_W-1:0]  = count_q;
         RIX_DEV:   reg_rdata[DEV_W-1:0]  = dev_q;
         default: ;
      endcase
   end

   assign irq       = irq_q;
   assign cfg_mword = maddr_q[ADDR_W-1:OFS_W];
   assign cfg_words = count_q[CNT_W-1:OFS_W];
   assign cfg_dev   = dev_q;

endmodule

// File: rtl/page_dma_xfer.sv
module page_dma_xfer
   import page_dma_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 16,
   parameter int DEV_W      = 8,
   parameter int PAGE_BYTES = 4096
) (
   input  logic                                             clk,
   input  logic                                             rst_n,
   input  logic                                             go,
   input  logic                                             go_dir,
   input  logic [ADDR_W-$clog2(DATA_W/8)-1:0]               cfg_mword,
   input  logic [CNT_W-$clog2(DATA_W/8)-1:0]                cfg_words,
   input  logic [DEV_W-1:0]                                 cfg_dev,
   output logic                                             busy,
   output logic                                             done_set,
   output logic                                             bus_req,
   input  logic                                             bus_gnt,
   output logic                                             mem_en,
   output logic                                             mem_we,
   output logic [ADDR_W-1:0]                                mem_addr,
   output logic [DATA_W-1:0]                                mem_wdata,
   input  logic [DATA_W-1:0]                                mem_rdata,
   input  logic                                             mem_rdy,
   output logic [DEV_W-1:0]                                 dev_addr,
   output logic                                             dev_rd,
   output logic                                             dev_wr,
   output logic [DATA_W-1:0]                                dev_wdata,
   input  logic [DATA_W-1:0]                                dev_rdata,
   input  logic                                             dev_rdy
);
   localparam int WORD_BYTES = DATA_W / 8;
   localparam int OFS_W      = $clog2(WORD_BYTES);
   localparam int WCNT_W     = CNT_W - OFS_W;
   localparam int PG_OFS_W   = $clog2(PAGE_BYTES);

   xfer_state_e       state_q;
   logic              dir_q;
   logic [ADDR_W-1:0] cur_addr;
   logic [WCNT_W-1:0] rem_q;
   logic [WCNT_W-1:0] seg_left;
   logic [WCNT_W-1:0] seg_words;
   logic [DATA_W-1:0] hold_q;
   logic [DEV_W-1:0]  dev_q;
   logic              src_ok;
   logic              dst_ok;

   page_dma_seg #(
      .PAGE_BYTES (PAGE_BYTES),
      .WORD_BYTES (WORD_BYTES),
      .WCNT_W     (WCNT_W)
   ) u_seg (
      .page_ofs  (cur_addr[PG_OFS_W-1:0]),
      .rem_words (rem_q),
      .seg_words (seg_words)
   );

   assign src_ok = dir_q ? mem_rdy : dev_rdy;
   assign dst_ok = dir_q ? dev_rdy : mem_rdy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= XS_IDLE;
         dir_q    <= 1'b0;
         cur_addr <= '0;
         rem_q    <= '0;
         seg_left <= '0;
         hold_q   <= '0;
         dev_q    <= '0;
      end else begin
         case (state_q)
            XS_IDLE: begin
               if (go) begin
                  dir_q    <= go_dir;
                  cur_addr <= {cfg_mword, {OFS_W{1'b0}}};
                  rem_q    <= cfg_words;
                  dev_q    <= cfg_dev;
                  if (cfg_words != '0) begin
                     state_q <= XS_REQ;
                  end
               end
            end
            XS_REQ: begin
               if (bus_gnt) begin
                  seg_left <= seg_words;
                  state_q  <= XS_FETCH;
               end
            end
            XS_FETCH: begin
               if (src_ok) begin
                  hold_q  <= dir_q ? mem_rdata : dev_rdata;
                  state_q <= XS_STORE;
               end
            end
            XS_STORE: begin
               if (dst_ok) begin
                  cur_addr <= cur_addr + ADDR_W'(WORD_BYTES);
                  rem_q    <= rem_q - WCNT_W'(1);
                  seg_left <= seg_left - WCNT_W'(1);
                  state_q  <= (seg_left == WCNT_W'(1)) ? XS_REL : XS_FETCH;
               end
            end
            XS_REL: begin
               state_q <= (rem_q == '0) ? XS_IDLE : XS_REQ;
            end
            default: state_q <= XS_IDLE;
         endcase
      end
   end

   always_comb begin
      busy     = (state_q != XS_IDLE);
      done_set = ((state_q == XS_IDLE) && go && (cfg_words == '0)) ||
                 ((state_q == XS_REL) && (rem_q == '0));
      bus_req  = (state_q == XS_REQ) || (state_q == XS_FETCH) || (state_q == XS_STORE);
      mem_en   = ((state_q == XS_FETCH) && dir_q) || ((state_q == XS_STORE) && !dir_q);
      mem_we   = (state_q == XS_STORE) && !dir_q;
      dev_rd   = (state_q == XS_FETCH) && !dir_q;
      dev_wr   = (state_q == XS_STORE) && dir_q;
   end

   assign mem_addr  = cur_addr;
   assign mem_wdata = hold_q;
   assign dev_wdata = hold_q;
   assign dev_addr  = dev_q;

endmodule

// File: rtl/page_dma_engine.sv
module page_dma_engine
   import page_dma_pkg::*;
#(
   parameter int REG_W      = 32,
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 16,
   parameter int DEV_W      = 8,
   parameter int PAGE_BYTES = 4096
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              irq,
   output logic              bus_req,
   input  logic              bus_gnt,
   output logic              mem_en,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_rdy,
   output logic [DEV_W-1:0]  dev_addr,
   output logic              dev_rd,
   output logic              dev_wr,
   output logic [DATA_W-1:0] dev_wdata,
   input  logic [DATA_W-1:0] dev_rdata,
   input  logic              dev_rdy
);
   localparam int WORD_BYTES = DATA_W / 8;
   localparam int OFS_W      = $clog2(WORD_BYTES);
   localparam int PG_OFS_W   = $clog2(PAGE_BYTES);

   generate
      if ((DATA_W % 8) != 0 || (1 << OFS_W) != WORD_BYTES || WORD_BYTES < 2) begin : g_bad_data
         $error("DATA_W must be a power-of-two number of bytes, at least two");
      end
      if ((1 << PG_OFS_W) != PAGE_BYTES || PAGE_BYTES < 2 * WORD_BYTES) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two holding at least two words");
      end
      if (ADDR_W <= PG_OFS_W || ADDR_W > REG_W) begin : g_bad_addr
         $error("ADDR_W must exceed the page offset and fit a register");
      end
      if (CNT_W <= OFS_W || CNT_W > REG_W || DEV_W > REG_W || REG_W < 2) begin : g_bad_regs
         $error("count and device widths must fit a register");
      end
   endgenerate

   logic                    busy_w;
   logic                    done_w;
   logic                    irq_clr_w;
   logic                    go_w;
   logic                    go_dir_w;
   logic [ADDR_W-OFS_W-1:0] mword_w;
   logic [CNT_W-OFS_W-1:0]  words_w;
   logic [DEV_W-1:0]        cdev_w;

   page_dma_regs #(
      .REG_W  (REG_W),
      .ADDR_W (ADDR_W),
      .CNT_W  (CNT_W),
      .DEV_W  (DEV_W),
      .OFS_W  (OFS_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .busy      (busy_w),
      .done_set  (done_w),
      .irq       (irq),
      .irq_clr   (irq_clr_w),
      .go        (go_w),
      .go_dir    (go_dir_w),
      .cfg_mword (mword_w),
      .cfg_words (words_w),
      .cfg_dev   (cdev_w)
   );

   page_dma_xfer #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .CNT_W      (CNT_W),
      .DEV_W      (DEV_W),
      .PAGE_BYTES (PAGE_BYTES)
   ) u_xfer (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go_w),
      .go_dir    (go_dir_w),
      .cfg_mword (mword_w),
      .cfg_words (words_w),
      .cfg_dev   (cdev_w),
      .busy      (busy_w),
      .done_set  (done_w),
      .bus_req   (bus_req),
      .bus_gnt   (bus_gnt),
      .mem_en    (mem_en),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_rdy   (mem_rdy),
      .dev_addr  (dev_addr),
      .dev_rd    (dev_rd),
      .dev_wr    (dev_wr),
      .dev_wdata (dev_wdata),
      .dev_rdata (dev_rdata),
      .dev_rdy   (dev_rdy)
   );

endmodule

// File: rtl/page_dma_engine_chk.sv
module page_dma_engine_chk #(
   parameter int ADDR_W     = 32,
   parameter int PAGE_BYTES = 4096
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_gnt,
   input logic              mem_en,
   input logic              mem_rdy,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              busy,
   input logic              irq,
   input logic              irq_clr
);
   localparam int PG_OFS_W = $clog2(PAGE_BYTES);

   logic [ADDR_W-1:0] mem_page;
   logic [ADDR_W-1:0] seg_page;
   logic              in_seg;

   assign mem_page = mem_addr >> PG_OFS_W;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_seg   <= 1'b0;
         seg_page <= '0;
      end else if (!bus_req) begin
         in_seg <= 1'b0;
      end else if (mem_en && mem_rdy && !in_seg) begin
         in_seg   <= 1'b1;
         seg_page <= mem_page;
      end
   end

   // R4
   mem_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> (bus_gnt && bus_req));

   // R4
   req_until_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt) |=> bus_req);

   // R5
   one_page_per_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && in_seg && mem_en) |-> (mem_page == seg_page));

   // R7
   done_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> irq);

   // R8
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_clr) |=> irq);

   // R9
   idle_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!bus_req && !mem_en));

endmodule

bind page_dma_engine page_dma_engine_chk #(
   .ADDR_W     (ADDR_W),
   .PAGE_BYTES (PAGE_BYTES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_req  (bus_req),
   .bus_gnt  (bus_gnt),
   .mem_en   (mem_en),
   .mem_rdy  (mem_rdy),
   .mem_addr (mem_addr),
   .busy     (busy_w),
   .irq      (irq),
   .irq_clr  (irq_clr_w)
);

// File: tb/page_dma_engine_bench.sv
module page_dma_engine_bench;
   localparam int CLK_PERIOD = 10;
   localparam int PAGE       = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq, bus_req, mem_en, mem_we, dev_rd, dev_wr;
   logic        bus_gnt = 1'b0;
   logic [31:0] mem_addr, mem_wdata, dev_wdata, mem_rdata, dev_rdata;
   logic        mem_rdy = 1'b1;
   logic        dev_rdy = 1'b1;
   logic [7:0]  dev_addr;

   logic [31:0] mem_model [0:255];
   logic [31:0] dev_sink  [0:255];
   int dev_rd_cnt = 0, dev_wr_cnt = 0, seg_cnt = 0, cross_err = 0, hold_err = 0;
   int seg_len [0:15];
   logic hold = 1'b0, stall = 1'b0, prev_req = 1'b0, pend_rd = 1'b0, in_grant = 1'b0;
   logic [31:0] grant_page = '0;
   int checks = 0, fails = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   assign mem_rdata = mem_model[mem_addr[9:2]];
   assign dev_rdata = 32'hD000_0000 + 32'(dev_rd_cnt);

   page_dma_engine #(.PAGE_BYTES(PAGE)) u_page_dma_engine (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_en(mem_en), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_rdy(mem_rdy), .dev_addr(dev_addr), .dev_rd(dev_rd), .dev_wr(dev_wr),
      .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .dev_rdy(dev_rdy));

   // Memory, device and arbiter models, acting between clock edges
   always @(negedge clk) begin
      logic nm, nd;
      if (pend_rd) dev_rd_cnt = dev_rd_cnt + 1;
      pend_rd = 1'b0;
      nm = stall ? ~mem_rdy : 1'b1;
      nd = stall ? mem_rdy : 1'b1;
      mem_rdy = nm;
      dev_rdy = nd;
      bus_gnt = bus_req && !hold;
      if (bus_req && !prev_req) begin
         seg_len[seg_cnt % 16] = 0;
         seg_cnt = seg_cnt + 1;
      end
      if (!bus_req) in_grant = 1'b0;
      if (mem_en && hold) hold_err = hold_err + 1;
      if (mem_en && mem_rdy) begin
         seg_len[(seg_cnt - 1) % 16] = seg_len[(seg_cnt - 1) % 16] + 1;
         if (!in_grant) begin
            in_grant = 1'b1;
            grant_page = mem_addr / PAGE;
         end else if (mem_addr / PAGE != grant_page) begin
            cross_err = cross_err + 1;
         end
         if (mem_we) mem_model[mem_addr[9:2]] = mem_wdata;
      end
      if (dev_rd && dev_rdy) pend_rd = 1'b1;
      if (dev_wr && dev_rdy) begin
         dev_sink[dev_wr_cnt % 256] = dev_wdata;
         dev_wr_cnt = dev_wr_cnt + 1;
      end
      prev_req = bus_req;
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      reg_addr = a; #1; d = reg_rdata;
   endtask

   task automatic wait_irq(input string req);
      int n = 0;
      while (!irq && n < 500) begin @(posedge clk); #1; n++; end
      chk(req, {31'b0, irq}, 32'd1);
   endtask

   task automatic clear_irq();
      wr(3'd1, 32'h1);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      chk("R1 irq", {31'b0, irq}, 0);
      chk("R1 bus", {28'b0, bus_req, mem_en, dev_rd, dev_wr}, 0);
      for (int i = 0; i < 5; i++) begin rd(3'(i), v); chk("R1 regs", v, 0); end
   endtask

   task automatic t_program();
      logic [31:0] v;
      wr(3'd2, 32'h0000_0123); wr(3'd3, 32'h0000_0010); wr(3'd4, 32'h0000_005A);
      rd(3'd2, v); chk("R2 maddr", v, 32'h123);
      rd(3'd3, v); chk("R2 count", v, 32'h10);
      rd(3'd4, v); chk("R2 dev", v, 32'h5A);
      wr(3'd0, 32'h2);
      rd(3'd0, v); chk("R2 ctrl dir", v, 32'h2);
      rd(3'd1, v); chk("R3 no start without go", v, 32'h0);
   endtask

   task automatic t_dev2mem();
      int base_rd = dev_rd_cnt, base_seg = seg_cnt;
      bit saw_dev = 0;
      mem_model[8] = 32'h5E5E_5E5E;
      wr(3'd2, 32'h11); wr(3'd3, 32'h13); wr(3'd4, 32'h21);
      wr(3'd0, 32'h1);
      for (int n = 0; n < 200 && !irq; n++) begin
         if (dev_rd && dev_addr == 8'h21) saw_dev = 1;
         @(posedge clk); #1;
      end
      chk("R7 irq", {31'b0, irq}, 1);
      chk("R2 dev_addr used", {31'b0, saw_dev}, 1);
      for (int i = 0; i < 4; i++)
         chk("R3 dev2mem data", mem_model[4 + i], 32'hD000_0000 + 32'(base_rd + i));
      chk("R3 low bits ignored", mem_model[8], 32'h5E5E_5E5E);
      chk("R6 one segment", 32'(seg_cnt - base_seg), 1);
      clear_irq();
   endtask

   task automatic t_cross();
      int base_wr = dev_wr_cnt, base_seg = seg_cnt;
      for (int k = 0; k < 256; k++) mem_model[k] = 32'hA500_0000 + 32'(k);
      wr(3'd2, 32'h38); wr(3'd3, 32'd80);
      wr(3'd0, 32'h3);
      wait_irq("R7 cross irq");
      chk("R3 word count", 32'(dev_wr_cnt - base_wr), 20);
      for (int i = 0; i < 20; i++)
         chk("R3 mem2dev data", dev_sink[(base_wr + i) % 256], 32'hA500_0000 + 32'(14 + i));
      chk("R6 three segments", 32'(seg_cnt - base_seg), 3);
      chk("R5 seg0 len", 32'(seg_len[(base_seg + 0) % 16]), 2);
      chk("R5 seg1 len", 32'(seg_len[(base_seg + 1) % 16]), 16);
      chk("R5 seg2 len", 32'(seg_len[(base_seg + 2) % 16]), 2);
      chk("R5 no page crossing", 32'(cross_err), 0);
      clear_irq();
   endtask

   task automatic t_aligned();
      int base_seg = seg_cnt;
      wr(3'd2, 32'h80); wr(3'd3, 32'd68);
      wr(3'd0, 32'h1);
      wait_irq("R7 aligned irq");
      chk("R6 two segments", 32'(seg_cnt - base_seg), 2);
      chk("R5 full page seg", 32'(seg_len[base_seg % 16]), 16);
      chk("R5 tail seg", 32'(seg_len[(base_seg + 1) % 16]), 1);
      clear_irq();
   endtask

   task automatic t_zero();
      int base_seg = seg_cnt;
      logic [31:0] v;
      chk("R8 cleared before zero job", {31'b0, irq}, 0);
      wr(3'd3, 32'd0);
      wr(3'd0, 32'h1);
      chk("R9 irq at once", {31'b0, irq}, 1);
      rd(3'd1, v); chk("R9 not busy", v & 32'h1, 0);
      clear_irq();
      wr(3'd3, 32'd3);
      wr(3'd0, 32'h3);
      chk("R9 sub-word count", {31'b0, irq}, 1);
      repeat (3) @(posedge clk); #1;
      chk("R9 no request", 32'(seg_cnt - base_seg), 0);
      clear_irq();
   endtask

   task automatic t_irq_hold();
      wr(3'd2, 32'h300); wr(3'd3, 32'd4);
      wr(3'd0, 32'h1);
      wait_irq("R7 irq");
      repeat (10) @(posedge clk); #1;
      chk("R8 sticky", {31'b0, irq}, 1);
      wr(3'd1, 32'h0);
      chk("R8 clear bit zero keeps irq", {31'b0, irq}, 1);
      wr(3'd1, 32'h1);
      chk("R8 cleared", {31'b0, irq}, 0);
   endtask

   task automatic t_busy();
      int base_seg = seg_cnt, base_rd = dev_rd_cnt;
      logic [31:0] v;
      hold = 1'b1;
      wr(3'd2, 32'h200); wr(3'd3, 32'd8); wr(3'd4, 32'h33);
      wr(3'd0, 32'h1);
      repeat (5) @(posedge clk); #1;
      chk("R4 request held", {31'b0, bus_req}, 1);
      chk("R4 no access ungranted", 32'(hold_err), 0);
      rd(3'd1, v); chk("R10 busy bit", v & 32'h1, 1);
      wr(3'd2, 32'h300); rd(3'd2, v); chk("R10 maddr locked", v, 32'h200);
      wr(3'd3, 32'h40);  rd(3'd3, v); chk("R10 count locked", v, 32'd8);
      wr(3'd4, 32'h77);  rd(3'd4, v); chk("R10 dev locked", v, 32'h33);
      wr(3'd0, 32'h3);   rd(3'd0, v); chk("R10 ctrl locked", v, 32'h0);
      hold = 1'b0;
      wait_irq("R7 busy job irq");
      rd(3'd1, v); chk("R10 idle after", v & 32'h1, 0);
      chk("R10 second start ignored", 32'(seg_cnt - base_seg), 1);
      chk("R3 busy job word0", mem_model[128], 32'hD000_0000 + 32'(base_rd));
      chk("R3 busy job word1", mem_model[129], 32'hD000_0000 + 32'(base_rd + 1));
      clear_irq();
   endtask

   task automatic t_stall();
      int base_wr = dev_wr_cnt;
      for (int k = 0; k < 256; k++) mem_model[k] = 32'h3C00_0000 + 32'(k * 3);
      stall = 1'b1;
      wr(3'd2, 32'h140); wr(3'd3, 32'd24);
      wr(3'd0, 32'h3);
      wait_irq("R11 stall irq");
      stall = 1'b0;
      chk("R11 word count", 32'(dev_wr_cnt - base_wr), 6);
      for (int i = 0; i < 6; i++)
         chk("R11 data", dev_sink[(base_wr + i) % 256], 32'h3C00_0000 + 32'((80 + i) * 3));
      clear_irq();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int k = 0; k < 256; k++) begin mem_model[k] = '0; dev_sink[k] = '0; end
      for (int k = 0; k < 16; k++) seg_len[k] = 0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_program();
      t_dev2mem();
      t_cross();
      t_aligned();
      t_zero();
      t_irq_hold();
      t_busy();
      t_stall();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule